// File: doc/BRIEF.md
# Checkerboard Reversal Video Stimulus Generator

This block drives a VGA monitor with a pattern-reversal visual stimulus. It runs a free-running raster scan from the pixel clock and produces active-low horizontal and vertical sync. From the scan position it paints a 4×4 grid of squares in the visible area. The squares alternate between black and full-intensity green. Only the green channel carries picture data, and red and blue are tied to zero.

A one-clock start pulse arms a timed run. The run begins at the next start of vertical blanking. While it runs, the polarity of the checkerboard flips after each fixed number of frames. It stops after a fixed number of phases. Every change of phase, start and stop falls at the first clock of vertical blanking, so each visible frame is drawn with a single polarity. Outside a run the screen is black, and sync keeps running.

The default timing is 640×480 at 60 Hz, with 60 frames per phase and 10 phases. That gives a one-second reversal period over a ten-second run. All of these values are parameters. Every video output is registered, so each output reflects the scan position of the previous clock.

Top module: `checkerboard_stim`

## Requirements
- R1: A line lasts H_VIS+H_FRONT+H_PULSE+H_BACK clocks (800 by default). `hsync_n` is low for H_PULSE clocks, starting at horizontal position H_VIS+H_FRONT, and high at all other positions. It is high during reset.
- R2: A frame lasts V_VIS+V_FRONT+V_PULSE+V_BACK lines (525 by default). `vsync_n` is low for every clock of lines V_VIS+V_FRONT through V_VIS+V_FRONT+V_PULSE-1, and high on all other lines. It is high during reset.
- R3: `green` is 0 whenever the horizontal position is H_VIS or greater, or the line is V_VIS or greater.
- R4: During a run, in the visible area, the column is x/(H_VIS/4) and the row is y/(V_VIS/4). `green` is 8'hFF when bit 0 of the column XOR bit 0 of the row XOR the phase bit equals 1, and 0 otherwise. The phase is 0 in the first frames of a run.
- R5: `red` and `blue` are 0 at all times.
- R6: After reset and whenever no run is active, `stim_active` is 0 and `green` is 0, while sync continues.
- R7: A start pulse sampled while idle arms the block, and this includes a pulse on the first clock of vertical blanking itself. The run begins at the next clock where the scan is at position 0 of line V_VIS. `stim_active` rises on the following clock and stays 0 until then.
- R8: The phase inverts after every FRAMES_PER_PHASE frames of a run, and only at the first clock of vertical blanking.
- R9: After PHASE_COUNT phases the run ends at the first clock of vertical blanking, and `stim_active` then returns to 0. `stim_active` stays high for exactly FRAMES_PER_PHASE×PHASE_COUNT frames of clocks.
- R10: A start pulse during a run has no effect, and the run keeps its original length.
- R11: All video outputs lag the scan by one register. The first clock after reset is released shows position (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-clock request to begin a timed run |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 8 | Red channel, always zero |
| green | output | 8 | Green luminance of the checkerboard |
| blue | output | 8 | Blue channel, always zero |
| stim_active | output | 1 | High while a timed run is in progress |

## Verification
A scoreboard model of the raster and of the run schedule predicts every output on every clock. This catches a sync pulse that is off by one position. It also catches squares painted across the blanking interval, and a phase flip in the middle of a frame, which would show up as a torn frame with two polarities. The bench sends a start pulse while idle and another in the middle of a run. A design that restarts or extends the run would produce a longer active window than FRAMES_PER_PHASE×PHASE_COUNT frames. A design that starts the run at once, without waiting for blanking, would raise `stim_active` early and paint a partial first frame.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  // true when pos lies in [first, first+len)
  function automatic logic in_window(input int unsigned pos,
                                     input int unsigned first,
                                     input int unsigned len);
    return (pos >= first) && (pos < first + len);
  endfunction

  // checker square parity for pixel (x,y) with square size tw x th
  function automatic logic square_lit(input int unsigned x,
                                      input int unsigned y,
                                      input int unsigned tw,
                                      input int unsigned th,
                                      input logic phase);
    int unsigned col;
    int unsigned row;
    col = x / tw;
    row = y / th;
    return col[0] ^ row[0] ^ phase;
  endfunction

endpackage

// File: rtl/cbs_scan.sv
module cbs_scan #(
  parameter int unsigned H_VIS   = 640,
  parameter int unsigned H_FRONT = 16,
  parameter int unsigned H_PULSE = 96,
  parameter int unsigned H_BACK  = 48,
  parameter int unsigned V_VIS   = 480,
  parameter int unsigned V_FRONT = 10,
  parameter int unsigned V_PULSE = 2,
  parameter int unsigned V_BACK  = 33,
  parameter int unsigned HW = $clog2(H_VIS + H_FRONT + H_PULSE + H_BACK),
  parameter int unsigned VW = $clog2(V_VIS + V_FRONT + V_PULSE + V_BACK)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hpos,
  output logic [VW-1:0] vpos,
  output logic          hs_n,
  output logic          vs_n,
  output logic          vblank_start
);
  localparam int unsigned H_TOT = H_VIS + H_FRONT + H_PULSE + H_BACK;
  localparam int unsigned V_TOT = V_VIS + V_FRONT + V_PULSE + V_BACK;

  logic line_end;
  logic frame_end;

  assign line_end  = (hpos == HW'(H_TOT - 1));
  assign frame_end = line_end && (vpos == VW'(V_TOT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos <= '0;
      vpos <= '0;
    end else if (line_end) begin
      hpos <= '0;
      vpos <= frame_end ? '0 : vpos + 1'b1;
    end else begin
      hpos <= hpos + 1'b1;
    end
  end

  assign hs_n = !cbs_pkg::in_window(32'(hpos), H_VIS + H_FRONT, H_PULSE);
  assign vs_n = !cbs_pkg::in_window(32'(vpos), V_VIS + V_FRONT, V_PULSE);
  assign vblank_start = (hpos == '0) && (vpos == VW'(V_VIS));

  a_r1_line_wrap: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (hpos == '0));
  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (vpos == '0));
  a_r2_line_bound: assert property (@(posedge clk) disable iff (rst)
    (vpos < VW'(V_TOT)) && (hpos < HW'(H_TOT)));

endmodule

// File: rtl/cbs_seq.sv
module cbs_seq #(
  parameter int unsigned FRAMES_PER_PHASE = 60,
  parameter int unsigned PHASE_COUNT      = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic vblank_start,
  output logic running,
  output logic phase
);
  localparam int unsigned FW = $clog2(FRAMES_PER_PHASE + 1);
  localparam int unsigned PW = $clog2(PHASE_COUNT + 1);

  logic          armed;
  logic [FW-1:0] frame_cnt;
  logic [PW-1:0] phase_cnt;
  logic          go;
  logic          phase_done;
  logic          run_done;

  assign go         = armed || start;
  assign phase_done = (frame_cnt == FW'(FRAMES_PER_PHASE - 1));
  assign run_done   = phase_done && (phase_cnt == PW'(PHASE_COUNT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      running   <= 1'b0;
      phase     <= 1'b0;
      frame_cnt <= '0;
      phase_cnt <= '0;
    end else begin
      if (!running && start) armed <= 1'b1;
      if (vblank_start) begin
        if (running) begin
          if (!phase_done) begin
            frame_cnt <= frame_cnt + 1'b1;
          end else begin
            frame_cnt <= '0;
            if (run_done) begin
              running   <= 1'b0;
              phase     <= 1'b0;
              phase_cnt <= '0;
            end else begin
              phase     <= !phase;
              phase_cnt <= phase_cnt + 1'b1;
            end
          end
        end else if (go) begin
          running   <= 1'b1;
          armed     <= 1'b0;
          phase     <= 1'b0;
          frame_cnt <= '0;
          phase_cnt <= '0;
        end
      end
    end
  end

  a_r8_phase_at_vblank: assert property (@(posedge clk) disable iff (rst)
    !vblank_start |=> $stable(phase));
  a_r10_run_holds: assert property (@(posedge clk) disable iff (rst)
    (running && !vblank_start) |=> running);
  a_r7_waits_blank: assert property (@(posedge clk) disable iff (rst)
    (!running && !vblank_start) |=> !running);
  a_r9_stop_at_blank: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> $past(vblank_start));

endmodule

// File: rtl/cbs_paint.sv
module cbs_paint #(
  parameter int unsigned H_VIS = 640,
  parameter int unsigned V_VIS = 480,
  parameter int unsigned GRID  = 4,
  parameter int unsigned HW    = 10,
  parameter int unsigned VW    = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hpos,
  input  logic [VW-1:0] vpos,
  input  logic          hs_n,
  input  logic          vs_n,
  input  logic          running,
  input  logic          phase,
  output logic          hs_q,
  output logic          vs_q,
  output logic [7:0]    green_q
);
  localparam int unsigned TW = H_VIS / GRID;
  localparam int unsigned TH = V_VIS / GRID;

  logic in_view;
  logic lit;

  assign in_view = (hpos < HW'(H_VIS)) && (vpos < VW'(V_VIS));
  assign lit = cbs_pkg::square_lit(32'(hpos), 32'(vpos), TW, TH, phase);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q    <= 1'b1;
      vs_q    <= 1'b1;
      green_q <= '0;
    end else begin
      hs_q    <= hs_n;
      vs_q    <= vs_n;
      green_q <= (in_view && running && lit) ? 8'hFF : 8'h00;
    end
  end

  a_r3_blank_black: assert property (@(posedge clk) disable iff (rst)
    !$past(in_view) |-> (green_q == 8'h00));
  a_r6_idle_black: assert property (@(posedge clk) disable iff (rst)
    !$past(running) |-> (green_q == 8'h00));
  a_r4_full_level: assert property (@(posedge clk) disable iff (rst)
    (green_q == 8'h00) || (green_q == 8'hFF));

endmodule

// File: rtl/checkerboard_stim.sv
module checkerboard_stim #(
  parameter int unsigned H_VIS            = 640,
  parameter int unsigned H_FRONT          = 16,
  parameter int unsigned H_PULSE          = 96,
  parameter int unsigned H_BACK           = 48,
  parameter int unsigned V_VIS            = 480,
  parameter int unsigned V_FRONT          = 10,
  parameter int unsigned V_PULSE          = 2,
  parameter int unsigned V_BACK           = 33,
  parameter int unsigned FRAMES_PER_PHASE = 60,
  parameter int unsigned PHASE_COUNT      = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       hsync_n,
  output logic       vsync_n,
  output logic [7:0] red,
  output logic [7:0] green,
  output logic [7:0] blue,
  output logic       stim_active
);
  localparam int unsigned HW = $clog2(H_VIS + H_FRONT + H_PULSE + H_BACK);
  localparam int unsigned VW = $clog2(V_VIS + V_FRONT + V_PULSE + V_BACK);

  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;
  logic          hs_n;
  logic          vs_n;
  logic          vblank_start;
  logic          running;
  logic          phase;

  cbs_scan #(
    .H_VIS(H_VIS), .H_FRONT(H_FRONT), .H_PULSE(H_PULSE), .H_BACK(H_BACK),
    .V_VIS(V_VIS), .V_FRONT(V_FRONT), .V_PULSE(V_PULSE), .V_BACK(V_BACK),
    .HW(HW), .VW(VW)
  ) u_scan (
    .clk(clk), .rst(rst), .hpos(hpos), .vpos(vpos),
    .hs_n(hs_n), .vs_n(vs_n), .vblank_start(vblank_start)
  );

  cbs_seq #(
    .FRAMES_PER_PHASE(FRAMES_PER_PHASE), .PHASE_COUNT(PHASE_COUNT)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .vblank_start(vblank_start),
    .running(running), .phase(phase)
  );

  cbs_paint #(
    .H_VIS(H_VIS), .V_VIS(V_VIS), .GRID(4), .HW(HW), .VW(VW)
  ) u_paint (
    .clk(clk), .rst(rst), .hpos(hpos), .vpos(vpos), .hs_n(hs_n), .vs_n(vs_n),
    .running(running), .phase(phase),
    .hs_q(hsync_n), .vs_q(vsync_n), .green_q(green)
  );

  assign red         = 8'h00;
  assign blue        = 8'h00;
  assign stim_active = running;

endmodule

// File: tb/checkerboard_stim_test.sv
`timescale 1ns/1ps
module checkerboard_stim_test;
  localparam int HV = 16, HF = 2, HP = 3, HB = 3;
  localparam int VV = 8,  VF = 1, VP = 2, VB = 2;
  localparam int FPP = 3, NPH = 4;
  localparam int HT = HV + HF + HP + HB;
  localparam int VT = VV + VF + VP + VB;
  localparam int RUN_CYC = FPP * NPH * HT * VT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic hsync_n, vsync_n, stim_active;
  logic [7:0] red, green, blue;

  always #2 clk = ~clk;

  checkerboard_stim #(
    .H_VIS(HV), .H_FRONT(HF), .H_PULSE(HP), .H_BACK(HB),
    .V_VIS(VV), .V_FRONT(VF), .V_PULSE(VP), .V_BACK(VB),
    .FRAMES_PER_PHASE(FPP), .PHASE_COUNT(NPH)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .red(red), .green(green), .blue(blue), .stim_active(stim_active)
  );

  typedef struct packed {
    logic       hs;
    logic       vs;
    logic [7:0] g;
    logic       act;
    logic       view;
    logic       run;
    logic       ph;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // model state (driver side)
  int mx, my, mf, mp;
  bit m_run, m_arm, m_ph;

  always @(posedge clk) begin
    if (rst) begin
      mx = 0; my = 0; mf = 0; mp = 0;
      m_run = 0; m_arm = 0; m_ph = 0;
      q.delete();
    end else begin
      exp_t e;
      bit lit, evt, go;
      e.hs   = !((mx >= HV + HF) && (mx < HV + HF + HP));
      e.vs   = !((my >= VV + VF) && (my < VV + VF + VP));
      e.view = (mx < HV) && (my < VV);
      lit    = (((mx / (HV / 4)) % 2) != 0) ^ (((my / (VV / 4)) % 2) != 0) ^ m_ph;
      e.g    = (e.view && m_run && lit) ? 8'hFF : 8'h00;
      e.run  = m_run;
      e.ph   = m_ph;
      evt = (mx == 0) && (my == VV);
      go  = m_arm || start;
      if (!m_run && start) m_arm = 1;
      if (evt) begin
        if (m_run) begin
          if (mf < FPP - 1) mf++;
          else begin
            mf = 0;
            if (mp == NPH - 1) begin m_run = 0; m_ph = 0; mp = 0; end
            else begin mp++; m_ph = !m_ph; end
          end
        end else if (go) begin
          m_run = 1; m_arm = 0; m_ph = 0; mf = 0; mp = 0;
        end
      end
      e.act = m_run;
      q.push_back(e);
      if (mx == HT - 1) begin
        mx = 0;
        my = (my == VT - 1) ? 0 : my + 1;
      end else mx++;
    end
  end

  // monitor: R11 alignment is implied by comparing every clock
  always @(negedge clk) begin
    if (!rst && !finished && q.size() > 0) begin
      exp_t e;
      string gtag;
      e = q.pop_front();
      check(hsync_n == e.hs, "R1 hsync_n", hsync_n, e.hs);
      check(vsync_n == e.vs, "R2 vsync_n", vsync_n, e.vs);
      check(red == 8'h00 && blue == 8'h00, "R5 red|blue", red | blue, 0);
      if (!e.view) gtag = "R3 green";
      else if (!e.run) gtag = "R6 green";
      else if (e.ph) gtag = "R8 green";
      else gtag = "R4 green";
      check(green == e.g, gtag, green, e.g);
      check(stim_active == e.act, e.act ? "R7 stim_active" : "R9 stim_active",
            stim_active, e.act);
    end
  end

  // run length measurement
  int cur_len = 0;
  int last_len = 0;
  int runs_done = 0;
  always @(negedge clk) begin
    if (rst) cur_len = 0;
    else if (stim_active) cur_len++;
    else if (cur_len > 0) begin
      last_len = cur_len;
      runs_done++;
      cur_len = 0;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic finish_up();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // reset state
    check(hsync_n == 1'b1, "R1 reset hsync_n", hsync_n, 1);
    check(vsync_n == 1'b1, "R2 reset vsync_n", vsync_n, 1);
    check(green == 8'h00, "R6 reset green", green, 0);
    check(stim_active == 1'b0, "R6 reset stim_active", stim_active, 0);
    rst = 1'b0;
    repeat (2 * HT * VT) @(negedge clk);
    check(stim_active == 1'b0, "R6 idle stim_active", stim_active, 0);
    // first run, with a second request mid-run
    pulse_start();
    @(negedge clk);
    check(stim_active == 1'b0, "R7 waits for blanking", stim_active, 0);
    while (!stim_active) @(negedge clk);
    repeat (5 * HT * VT) @(negedge clk);
    pulse_start();
    while (runs_done < 1) @(negedge clk);
    check(last_len == RUN_CYC, "R10 run length with extra start", last_len, RUN_CYC);
    // second run: armed twice before blanking
    repeat (HT * 3 + 5) @(negedge clk);
    pulse_start();
    repeat (7) @(negedge clk);
    pulse_start();
    while (runs_done < 2) @(negedge clk);
    check(last_len == RUN_CYC, "R9 run length", last_len, RUN_CYC);
    repeat (2 * HT * VT) @(negedge clk);
    check(stim_active == 1'b0, "R9 stays idle", stim_active, 0);
    check(runs_done == 2, "R10 no extra run", runs_done, 2);
    finish_up();
  end

endmodule